// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Logic

This block holds the sample words that travel between a system bus and the serial shifter of an audio port. Bus writes to the data address go into a transmit FIFO, and the shifter drains it. The shifter fills a receive FIFO, and bus reads drain it. Each FIFO stores 32-bit words and is `DEPTH` entries deep (64 by default). A control/status register carries the enables, the flush requests, the status thresholds, the DMA enable, sticky error flags and a set of live status flags. A level register sets four fill levels. These levels drive a request line and a panic line for each direction toward a DMA engine.

The serial side runs on the bus clock and is qualified by a bit-clock enable strobe, `bclk_en`. Each cycle with `bclk_en` high counts as one bit-clock period. Three actions only complete after a set number of those periods: a FIFO flush, the return of the written sync bit, and the settling of standby. Software can therefore poll the sync bit to learn when the serial side has seen its earlier writes.

Top module: `audio_fifo_dreq`

## Requirements
- R1: Each FIFO returns its words in the order they went in. A FIFO holds at most `DEPTH` words, and a bus write to the data address (address 1) while the transmit FIFO is full is dropped.
- R2: Status flags in the control register (address 0) track the fill levels:
  - bit 21 set when transmit is empty
  - bit 19 set when transmit is not full
  - bit 20 set when receive holds data
  - bit 22 set when receive is full
  After reset the control register reads 0x002A0000.
- R3: The transmit request is high when DMA enable (bit 9) and master enable (bit 0) are both set and the transmit fill is at or below the transmit request level (level register bits 14:8). The transmit panic is high under the same conditions against the panic level (bits 30:24). The level register (address 2) resets to 0x10303020.
- R4: The receive request is high when DMA enable and master enable are both set and the receive fill is above the receive request level (bits 6:0). The receive panic uses the panic level (bits 22:16) in the same way.
- R5: A shifter pop while transmit is empty presents a zero word and sets sticky error bit 15. The bit stays set until a control write with bit 15 set clears it.
- R6: A shifter push while receive is full drops the word and sets sticky error bit 16. A control write with bit 16 set clears it.
- R7: Writing 1 to bit 3 (transmit) or bit 4 (receive) empties that FIFO on the second bit-clock tick after the write. Cycles without a tick do not advance the flush.
- R8: Control bit 24 reads back the value last written to it, but only after two bit-clock ticks.
- R9: Shifter pops and pushes are ignored until master enable and standby (bit 25) have both been set for four bit-clock ticks. Clearing either bit restarts that count.
- R10: Pops need bit 2 and pushes need bit 1. Bus writes into the transmit FIFO need master enable. Both requests and both panics are low while master enable is clear.
- R11: A bus read of the data address while receive is empty returns zero and has no other effect. It does not set an error and does not change the fill.
- R12: Bit 17 is set when the transmit fill is at or below T×`DEPTH`/4, where T is control bits 6:5. Bit 18 is set when the receive fill is at least R×`DEPTH`/4, where R is control bits 8:7. When R is 0, bit 18 instead means the receive FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | One-cycle strobe per bit-clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive at the data address) |
| reg_addr | input | 2 | Word address: 0 control/status, 1 data, 2 levels |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| tx_pop | input | 1 | Shifter takes one transmit word (qualified by `bclk_en`) |
| tx_word | output | 32 | Head of transmit FIFO, zero when empty |
| rx_push | input | 1 | Shifter delivers one receive word (qualified by `bclk_en`) |
| rx_word | input | 32 | Receive word from the shifter |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit DMA panic |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive DMA panic |

## Verification
Each FIFO is walked through every fill level from empty to full. At each level the request, panic and four status flags are compared against thresholds placed at different points. These sweeps separate at-or-below from strictly-above comparisons and show off-by-one errors at each boundary. Full drains with a distinct word per slot catch ordering and pointer-wrap faults. Bit-clock tick counts placed just before and just after the required number separate the flush, sync-return and standby delays from immediate or late versions. A stimulus on a disabled direction, a push on a full FIFO and a read on an empty FIFO each show whether that access leaked into the FIFO contents or the error flags.

// File: rtl/afd_pkg.sv
// Shared constants and types for the audio sample FIFO block.
// Register addresses, control/status bit positions and the level register layout.
package afd_pkg;

    localparam int WORD_W = 32;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_LVL  = 2'd2;

    localparam int B_EN    = 0;
    localparam int B_RXON  = 1;
    localparam int B_TXON  = 2;
    localparam int B_TXCLR = 3;
    localparam int B_RXCLR = 4;
    localparam int B_TXTHR = 5;
    localparam int B_RXTHR = 7;
    localparam int B_DMAEN = 9;
    localparam int B_TXERR = 15;
    localparam int B_RXERR = 16;
    localparam int B_TXW   = 17;
    localparam int B_RXR   = 18;
    localparam int B_TXD   = 19;
    localparam int B_RXD   = 20;
    localparam int B_TXE   = 21;
    localparam int B_RXF   = 22;
    localparam int B_SYNC  = 24;
    localparam int B_STBY  = 25;

    // Level register: four 7-bit fields on byte lanes, top bit of each lane zero.
    typedef struct packed {
        logic       pad3;
        logic [6:0] tx_panic;
        logic       pad2;
        logic [6:0] rx_panic;
        logic       pad1;
        logic [6:0] tx_req;
        logic       pad0;
        logic [6:0] rx_req;
    } lvl_cfg_t;

    localparam logic [31:0] LVL_MASK  = 32'h7F7F_7F7F;
    localparam logic [31:0] LVL_RESET = 32'h1030_3020;

endpackage

// File: rtl/afd_fifo.sv
// Synchronous sample FIFO with fill count and flush.
// Assumes DEPTH is a power of two. Push on full and pop on empty are ignored here;
// the caller decides whether they are errors. Flush wins over push and pop.
module afd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rp];
    assign level   = cnt;

    // Storage write; contents need no reset since the count gates all reads.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= din;
        end
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/afd_tick_count.sv
// Countdown in bit-clock ticks. A start loads TICKS; done pulses on the tick that
// takes the count from 1 to 0. A new start restarts the count.
module afd_tick_count #(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS+1);

    logic [CW-1:0] cnt;

    assign done = !start && tick && (cnt == CW'(1));

    // Load on start, step down on each tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(TICKS);
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/afd_tick_echo.sv
// Carries a single bit through STAGES registers that advance only on bit-clock ticks,
// so the output shows the input after STAGES ticks.
module afd_tick_echo #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Stage i shifts in its predecessor on a tick.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr[i] <= 1'b0;
            end else if (tick) begin
                if (i == 0) sr[i] <= din;
                else        sr[i] <= sr[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign dout = sr[STAGES-1];

endmodule

// File: rtl/audio_fifo_dreq.sv
// Transmit/receive sample FIFOs of a serial audio port with status and DMA requests.
// Assumes the serial shifter runs on clk qualified by bclk_en (one strobe per bit-clock
// period); tx_pop and rx_push are honoured only in cycles with bclk_en high.
module audio_fifo_dreq
    import afd_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int CLR_TICKS   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int STBY_TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_word,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_word,
    output logic              tx_dreq,
    output logic              tx_panic,
    output logic              rx_dreq,
    output logic              rx_panic
);
    localparam int LW  = $clog2(DEPTH+1);
    localparam int QTR = DEPTH / 4;
    localparam int SCW = $clog2(STBY_TICKS+1);

    // Control state
    logic       en_q, rxon_q, txon_q, dmaen_q, stby_q, sync_q;
    logic       txerr_q, rxerr_q;
    logic [1:0] txthr_q, rxthr_q;
    lvl_cfg_t   lvl_q;
    logic [SCW-1:0] stby_cnt;
    logic       stby_ready;

    // Decoded accesses
    logic wr_ctrl, wr_data, wr_lvl, rd_data;
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_lvl  = reg_wr && (reg_addr == A_LVL);
    assign rd_data = reg_rd && (reg_addr == A_DATA);

    // FIFO side signals
    logic [WORD_W-1:0] tx_head, rx_head;
    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_clr_done, rx_clr_done, sync_echo;
    logic              serial_on, tx_pop_q, rx_push_q, tx_under, rx_over;

    assign stby_ready = (stby_cnt == SCW'(STBY_TICKS));
    assign serial_on  = en_q && stby_ready;
    assign tx_pop_q   = tx_pop && bclk_en && serial_on && txon_q;
    assign rx_push_q  = rx_push && bclk_en && serial_on && rxon_q;
    assign tx_under   = tx_pop_q && tx_empty;
    assign rx_over    = rx_push_q && rx_full;

    // Control register, sticky errors and level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rxon_q  <= 1'b0;
            txon_q  <= 1'b0;
            dmaen_q <= 1'b0;
            stby_q  <= 1'b0;
            sync_q  <= 1'b0;
            txthr_q <= '0;
            rxthr_q <= '0;
            txerr_q <= 1'b0;
            rxerr_q <= 1'b0;
            lvl_q   <= lvl_cfg_t'(LVL_RESET);
        end else begin
            if (wr_ctrl) begin
                en_q    <= reg_wdata[B_EN];
                rxon_q  <= reg_wdata[B_RXON];
                txon_q  <= reg_wdata[B_TXON];
                dmaen_q <= reg_wdata[B_DMAEN];
                stby_q  <= reg_wdata[B_STBY];
                sync_q  <= reg_wdata[B_SYNC];
                txthr_q <= reg_wdata[B_TXTHR +: 2];
                rxthr_q <= reg_wdata[B_RXTHR +: 2];
            end
            if (tx_under)                             txerr_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[B_TXERR])   txerr_q <= 1'b0;
            if (rx_over)                              rxerr_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[B_RXERR])   rxerr_q <= 1'b0;
            if (wr_lvl) lvl_q <= lvl_cfg_t'(reg_wdata & LVL_MASK);
        end
    end

    // Standby settle counter: counts ticks while enabled and in standby.
    always_ff @(posedge clk) begin
        if (!rst_n || !(en_q && stby_q)) begin
            stby_cnt <= '0;
        end else if (bclk_en && !stby_ready) begin
            stby_cnt <= stby_cnt + SCW'(1);
        end
    end

    afd_tick_count #(.TICKS(CLR_TICKS)) u_txclr (
        .clk(clk), .rst_n(rst_n),
        .start(wr_ctrl && reg_wdata[B_TXCLR]),
        .tick(bclk_en), .done(tx_clr_done)
    );

    afd_tick_count #(.TICKS(CLR_TICKS)) u_rxclr (
        .clk(clk), .rst_n(rst_n),
        .start(wr_ctrl && reg_wdata[B_RXCLR]),
        .tick(bclk_en), .done(rx_clr_done)
    );

    afd_tick_echo #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick(bclk_en),
        .din(sync_q), .dout(sync_echo)
    );

    afd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_clr_done),
        .push(wr_data && en_q), .din(reg_wdata),
        .pop(tx_pop_q), .head(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    afd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_clr_done),
        .push(rx_push_q), .din(rx_word),
        .pop(rd_data), .head(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // Threshold level for a 2-bit quarter selector.
    function automatic logic [LW-1:0] quarter_lvl(input logic [1:0] t);
        return LW'(t) * LW'(QTR);
    endfunction

    logic txw, rxr, dma_on;
    assign txw    = (tx_level <= quarter_lvl(txthr_q));
    assign rxr    = (rxthr_q == 2'd0) ? !rx_empty : (rx_level >= quarter_lvl(rxthr_q));
    assign dma_on = en_q && dmaen_q;

    // DMA request and panic comparisons.
    always_comb begin
        tx_dreq  = dma_on && (32'(tx_level) <= 32'(lvl_q.tx_req));
        tx_panic = dma_on && (32'(tx_level) <= 32'(lvl_q.tx_panic));
        rx_dreq  = dma_on && (32'(rx_level) >  32'(lvl_q.rx_req));
        rx_panic = dma_on && (32'(rx_level) >  32'(lvl_q.rx_panic));
    end

    assign tx_word = tx_empty ? '0 : tx_head;

    // Read data multiplexer with the composed control/status word.
    always_comb begin
        logic [WORD_W-1:0] cs;
        cs                 = '0;
        cs[B_EN]           = en_q;
        cs[B_RXON]         = rxon_q;
        cs[B_TXON]         = txon_q;
        cs[B_TXTHR +: 2]   = txthr_q;
        cs[B_RXTHR +: 2]   = rxthr_q;
        cs[B_DMAEN]        = dmaen_q;
        cs[B_TXERR]        = txerr_q;
        cs[B_RXERR]        = rxerr_q;
        cs[B_TXW]          = txw;
        cs[B_RXR]          = rxr;
        cs[B_TXD]          = !tx_full;
        cs[B_RXD]          = !rx_empty;
        cs[B_TXE]          = tx_empty;
        cs[B_RXF]          = rx_full;
        cs[B_SYNC]         = sync_echo;
        cs[B_STBY]         = stby_q;
        case (reg_addr)
            A_CTRL:  reg_rdata = cs;
            A_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
            A_LVL:   reg_rdata = lvl_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/afd_chk.sv
// Property checker for audio_fifo_dreq, attached with bind below.
module afd_chk
    import afd_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bclk_en,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [1:0]                 reg_addr,
    input logic [31:0]                reg_wdata,
    input logic [31:0]                reg_rdata,
    input logic                       tx_dreq,
    input logic                       rx_dreq,
    input logic                       en_q,
    input logic                       dmaen_q,
    input logic                       txerr_q,
    input logic                       rxerr_q,
    input logic                       sync_echo,
    input logic                       stby_ready,
    input logic                       rx_empty,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_level) <= DEPTH) && (32'(rx_level) <= DEPTH));

    // R3
    tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dreq |-> (dmaen_q && en_q));

    // R4
    rx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dreq |-> (dmaen_q && en_q));

    // R5
    txerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txerr_q && !(ctrl_wr && reg_wdata[B_TXERR])) |=> txerr_q);

    // R6
    rxerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxerr_q && !(ctrl_wr && reg_wdata[B_RXERR])) |=> rxerr_q);

    // R8
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> $stable(sync_echo));

    // R9
    no_fill_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_ready |=> (rx_level <= $past(rx_level)));

    // R11
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && rx_empty) |-> (reg_rdata == '0));

endmodule

bind audio_fifo_dreq afd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
    .en_q(en_q), .dmaen_q(dmaen_q),
    .txerr_q(txerr_q), .rxerr_q(rxerr_q),
    .sync_echo(sync_echo), .stby_ready(stby_ready),
    .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_audio_fifo_dreq.sv
// Sweep bench for audio_fifo_dreq: walks both FIFOs through every fill level and
// probes the tick-delayed actions at their exact boundaries.
module tb_audio_fifo_dreq;

    logic        clk = 1'b0;
    logic        rst_n, bclk_en, reg_wr, reg_rd, tx_pop, rx_push;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, tx_word, rx_word;
    logic        tx_dreq, tx_panic, rx_dreq, rx_panic;

    int checks = 0;
    int errors = 0;

    localparam int D = 64;
    localparam logic [1:0] AC = 2'd0, AD = 2'd1, AL = 2'd2;
    localparam logic [31:0] EN = 32'h1, RXON = 32'h2, TXON = 32'h4, DMAEN = 32'h200,
                            STBY = 32'h0200_0000;

    always #5 clk = ~clk;

    audio_fifo_dreq dut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_word(tx_word),
        .rx_push(rx_push), .rx_word(rx_word),
        .tx_dreq(tx_dreq), .tx_panic(tx_panic),
        .rx_dreq(rx_dreq), .rx_panic(rx_panic)
    );

    function automatic logic [31:0] tpat(input int k);
        return 32'hA500_0000 | (32'(k) * 32'h0001_0101);
    endfunction
    function automatic logic [31:0] rpat(input int k);
        return 32'h5A00_0000 ^ (32'(k) * 32'h0103_0007);
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bclk_en = 1'b1;
            @(posedge clk); #1 bclk_en = 1'b0;
        end
    endtask

    task automatic spop(output logic [31:0] w);
        @(negedge clk);
        tx_pop = 1'b1; bclk_en = 1'b1;
        #2 w = tx_word;
        @(posedge clk); #1 tx_pop = 1'b0; bclk_en = 1'b0;
    endtask

    task automatic spush(input logic [31:0] w);
        @(negedge clk);
        rx_push = 1'b1; rx_word = w; bclk_en = 1'b1;
        @(posedge clk); #1 rx_push = 1'b0; bclk_en = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, w, cb;
        rst_n = 1'b0; bclk_en = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; tx_pop = 1'b0;
        rx_push = 1'b0; reg_addr = '0; reg_wdata = '0; rx_word = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        peek(AC, v); chk("R2 reset control/status", v, 32'h002A_0000);
        peek(AL, v); chk("R3 reset level register", v, 32'h1030_3020);
        chk("R3 no requests after reset", {28'd0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'd0);

        // R9: standby settle takes four ticks
        cb = EN | RXON | TXON | STBY;
        wr(AC, cb);
        spush(32'h1111_0001);
        tick(2);
        spush(32'h1111_0002);
        peek(AC, v); chk("R9 pushes ignored before four ticks", 32'(v[20]), 0);
        spush(32'h1111_0003);
        peek(AC, v); chk("R9 push accepted after settle", 32'(v[20]), 1);
        chk("R12 rx threshold zero means not empty", 32'(v[18]), 1);
        rd(AD, v); chk("R1 received word", v, 32'h1111_0003);
        rd(AD, v); chk("R11 empty read returns zero", v, 0);
        peek(AC, v); chk("R11 empty read leaves no data and no error", {v[20], v[16]}, 0);

        // Levels and thresholds
        wr(AL, (32'd2 << 24) | (32'd6 << 16) | (32'd5 << 8) | 32'd3);
        peek(AL, v); chk("R3 level register readback", v, 32'h0206_0503);
        cb = cb | DMAEN | (32'd2 << 5) | (32'd1 << 7);
        wr(AC, cb);

        // Transmit sweep over all fill levels
        for (int k = 0; k <= D; k++) begin
            peek(AC, v);
            chk($sformatf("R3 tx request at fill %0d", k), 32'(tx_dreq), 32'(k <= 5));
            chk($sformatf("R3 tx panic at fill %0d", k), 32'(tx_panic), 32'(k <= 2));
            chk($sformatf("R2 tx empty flag at fill %0d", k), 32'(v[21]), 32'(k == 0));
            chk($sformatf("R2 tx not-full flag at fill %0d", k), 32'(v[19]), 32'(k < D));
            chk($sformatf("R12 tx threshold flag at fill %0d", k), 32'(v[17]), 32'(k <= 32));
            if (k < D) wr(AD, tpat(k));
        end
        wr(AD, 32'hDEAD_BEEF);
        for (int k = 0; k < D; k++) begin
            spop(w);
            chk($sformatf("R1 tx order slot %0d", k), w, tpat(k));
        end
        peek(AC, v); chk("R1 write on full was dropped", 32'(v[21]), 1);

        // R5 underflow
        spop(w); chk("R5 pop on empty gives zero", w, 0);
        peek(AC, v); chk("R5 underflow sets error", 32'(v[15]), 1);
        tick(3);
        peek(AC, v); chk("R5 error stays set", 32'(v[15]), 1);
        wr(AC, cb | (32'd1 << 15));
        peek(AC, v); chk("R5 write-one clears error", 32'(v[15]), 0);

        // R3 DMA enable gating
        chk("R3 request with dma enabled and empty", 32'(tx_dreq), 1);
        wr(AC, cb & ~DMAEN);
        @(negedge clk); #2;
        chk("R3 request dropped without dma enable", {30'd0, tx_dreq, tx_panic}, 0);
        wr(AC, cb);

        // Receive sweep over all fill levels
        for (int k = 0; k <= D; k++) begin
            peek(AC, v);
            chk($sformatf("R4 rx request at fill %0d", k), 32'(rx_dreq), 32'(k > 3));
            chk($sformatf("R4 rx panic at fill %0d", k), 32'(rx_panic), 32'(k > 6));
            chk($sformatf("R2 rx data flag at fill %0d", k), 32'(v[20]), 32'(k > 0));
            chk($sformatf("R2 rx full flag at fill %0d", k), 32'(v[22]), 32'(k == D));
            chk($sformatf("R12 rx threshold flag at fill %0d", k), 32'(v[18]), 32'(k >= 16));
            if (k < D) spush(rpat(k));
        end
        spush(32'hBAD0_BAD0);
        peek(AC, v); chk("R6 overflow sets error", 32'(v[16]), 1);
        for (int k = 0; k < D; k++) begin
            rd(AD, w);
            chk($sformatf("R1 rx order slot %0d", k), w, rpat(k));
        end
        peek(AC, v); chk("R6 overflow word dropped", 32'(v[20]), 0);
        chk("R6 error stays set", 32'(v[16]), 1);
        wr(AC, cb | (32'd1 << 16));
        peek(AC, v); chk("R6 write-one clears error", 32'(v[16]), 0);

        // R7 flush after two ticks
        wr(AD, 32'h1); wr(AD, 32'h2); wr(AD, 32'h3);
        wr(AC, cb | (32'd1 << 3));
        repeat (5) @(posedge clk);
        peek(AC, v); chk("R7 no flush without ticks", 32'(v[21]), 0);
        tick(1);
        peek(AC, v); chk("R7 no flush after one tick", 32'(v[21]), 0);
        tick(1);
        peek(AC, v); chk("R7 tx flushed after two ticks", 32'(v[21]), 1);
        spush(32'h7); spush(32'h8);
        wr(AC, cb | (32'd1 << 4));
        tick(1);
        peek(AC, v); chk("R7 rx still holds data after one tick", 32'(v[20]), 1);
        tick(1);
        peek(AC, v); chk("R7 rx flushed after two ticks", 32'(v[20]), 0);

        // R8 sync echo
        cb = cb | (32'd1 << 24);
        wr(AC, cb);
        repeat (4) @(posedge clk);
        peek(AC, v); chk("R8 sync not back without ticks", 32'(v[24]), 0);
        tick(1);
        peek(AC, v); chk("R8 sync not back after one tick", 32'(v[24]), 0);
        tick(1);
        peek(AC, v); chk("R8 sync back after two ticks", 32'(v[24]), 1);

        // R10 direction and master gating
        wr(AC, cb & ~TXON);
        wr(AD, 32'hC0DE_0001);
        spop(w);
        peek(AC, v); chk("R10 pop ignored with tx off", {v[21], v[15]}, 0);
        wr(AC, cb);
        spop(w); chk("R10 pop after tx on", w, 32'hC0DE_0001);
        wr(AC, cb & ~RXON);
        spush(32'h9);
        peek(AC, v); chk("R10 push ignored with rx off", 32'(v[20]), 0);
        wr(AC, cb & ~EN);
        @(negedge clk); #2;
        chk("R10 requests low with master off", {28'd0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 0);
        wr(AD, 32'hC0DE_0002);
        spush(32'hA);
        wr(AC, cb);
        tick(4);
        peek(AC, v); chk("R10 bus write ignored with master off", 32'(v[21]), 1);
        chk("R10 push ignored with master off", 32'(v[20]), 0);
        spush(32'hB);
        rd(AD, w); chk("R9 serial works again after resettle", w, 32'hB);

        summary();
        $finish;
    end

endmodule